// File: doc/BRIEF.md
# Video Memory Serial Readout Port

This block models the read-out side of a two-port video memory. A random-access write port fills a small DRAM array that is organised as rows of 512 sixteen-bit words, one pixel per word in scanline order. A transfer command then copies one half of a chosen row, 256 words, into a serial register file in a single clock cycle. The command also places the serial pointer at a chosen start entry.

After a transfer, each cycle with the shift enable high presents the entry under the pointer on a registered 16-bit output and moves the pointer up by one. After the last entry the pointer wraps to entry 0. The serial register file is a separate copy of the row. Later writes to the array do not change what is being shifted out until the next transfer. A display controller issues a transfer at the start of each line segment and then clocks pixels out. A drawing engine can write the array at the same time.

Top module: `vram_serial_port`

## Requirements
- R1: While reset is held, `ser_data` is 0, `ser_ptr` is 0 and `ser_valid` is 0.
- R2: With `wr_en` high, `wr_data` is stored at row `wr_row`, column `wr_col` on the clock edge. A later transfer of that row half shows the new word.
- R3: On a clock edge where `xfer_req` is high, entry i of the serial buffer (i = 0..255) takes column `xfer_seg`*256 + i of row `xfer_row`. All 256 entries load on that one edge, and `ser_ptr` becomes `xfer_tap`.
- R4: On an edge where `shift_en` is high and `xfer_req` is low, `ser_data` takes the entry under `ser_ptr` and `ser_ptr` increases by one. Successive shifts therefore give ascending entries.
- R5: A shift taken with `ser_ptr` at 255 sets the pointer to 0, and the next shift outputs entry 0.
- R6: On an edge where `shift_en` and `xfer_req` are both low, `ser_data` and `ser_ptr` keep their values.
- R7: When `xfer_req` and `shift_en` are high in the same cycle, the transfer wins. `ser_data` keeps its value and `ser_ptr` becomes `xfer_tap`.
- R8: A write to a location in the same cycle as a transfer of that location leaves the old word in the serial buffer. Writes made after a transfer do not change the words that are shifted out.
- R9: `ser_valid` stays 0 after reset until the first transfer edge. From that edge on it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Array write strobe |
| wr_row | input | 2 | Write row address |
| wr_col | input | 9 | Write column address |
| wr_data | input | 16 | Write data |
| xfer_req | input | 1 | Row-to-serial transfer command |
| xfer_row | input | 2 | Row to transfer |
| xfer_seg | input | 1 | Row half: 0 = columns 0..255, 1 = columns 256..511 |
| xfer_tap | input | 8 | Start entry for the serial pointer |
| shift_en | input | 1 | Serial clock enable |
| ser_data | output | 16 | Registered serial output word |
| ser_ptr | output | 8 | Current serial pointer |
| ser_valid | output | 1 | Serial buffer holds transferred data |

## Verification
Two operations can fall in the same cycle. First, an array write can target a location that a transfer is copying in that cycle. The bench writes a marker word to a location inside the half being transferred, in the transfer's own cycle. The shifted words must show the old contents, and a second transfer must show the marker. Second, a transfer can coincide with a shift enable. The output word must stay unchanged while the pointer jumps to the new start entry, and the next shifts must read the freshly loaded row.

// File: rtl/vram_serial_port.sv
module vram_serial_port #(
  parameter int W     = 16,
  parameter int ROWS  = 4,
  parameter int COLS  = 512,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ROWS)-1:0]    wr_row,
  input  logic [$clog2(COLS)-1:0]    wr_col,
  input  logic [W-1:0]               wr_data,
  input  logic                       xfer_req,
  input  logic [$clog2(ROWS)-1:0]    xfer_row,
  input  logic [$clog2(COLS/DEPTH)-1:0] xfer_seg,
  input  logic [$clog2(DEPTH)-1:0]   xfer_tap,
  input  logic                       shift_en,
  output logic [W-1:0]               ser_data,
  output logic [$clog2(DEPTH)-1:0]   ser_ptr,
  output logic                       ser_valid
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int PW = $clog2(DEPTH);
  localparam int WORDS = ROWS * COLS;

  logic [W-1:0] mem [WORDS];
  logic [W-1:0] sam [DEPTH];

  wire [RW+CW-1:0] wr_addr = {wr_row, wr_col};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (xfer_req) begin
      for (int i = 0; i < DEPTH; i++)
        sam[i] <= mem[{xfer_row, xfer_seg, PW'(i)}];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_data  <= '0;
      ser_ptr   <= '0;
      ser_valid <= 1'b0;
    end else if (xfer_req) begin
      ser_ptr   <= xfer_tap;
      ser_valid <= 1'b1;
    end else if (shift_en) begin
      ser_data <= sam[ser_ptr];
      ser_ptr  <= ser_ptr + 1'b1;
    end
  end
endmodule

module vram_serial_port_chk #(
  parameter int W  = 16,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_req,
  input logic [PW-1:0] xfer_tap,
  input logic          shift_en,
  input logic [W-1:0]  ser_data,
  input logic [PW-1:0] ser_ptr,
  input logic          ser_valid
);
  p_tap_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> (ser_ptr == $past(xfer_tap)) && ser_valid);

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !xfer_req) |=> ser_ptr == PW'($past(ser_ptr) + 1'b1));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !xfer_req && ser_ptr == '1) |=> ser_ptr == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !xfer_req) |=> $stable(ser_ptr) && $stable(ser_data));

  p_xfer_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && shift_en) |=> $stable(ser_data));

  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |=> ser_valid);

  p_valid_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_valid && !xfer_req) |=> !ser_valid);
endmodule

bind vram_serial_port vram_serial_port_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_tap(xfer_tap),
  .shift_en(shift_en), .ser_data(ser_data), .ser_ptr(ser_ptr),
  .ser_valid(ser_valid)
);

// File: tb/vram_serial_port_tb.sv
`timescale 1ns/1ps
module vram_serial_port_tb;
  localparam int W = 16, ROWS = 4, COLS = 512, DEPTH = 256;
  localparam int RW = 2, CW = 9, PW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wr_en, xfer_req, shift_en;
  logic [RW-1:0] wr_row, xfer_row;
  logic [CW-1:0] wr_col;
  logic [W-1:0]  wr_data;
  logic          xfer_seg;
  logic [PW-1:0] xfer_tap;
  logic [W-1:0]  ser_data;
  logic [PW-1:0] ser_ptr;
  logic          ser_valid;

  vram_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .xfer_req(xfer_req), .xfer_row(xfer_row),
    .xfer_seg(xfer_seg), .xfer_tap(xfer_tap), .shift_en(shift_en),
    .ser_data(ser_data), .ser_ptr(ser_ptr), .ser_valid(ser_valid)
  );

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] mem_m [ROWS][COLS];
  logic [W-1:0] sam_m [DEPTH];
  int ptr_m = 0;
  logic [W-1:0] out_m = '0;
  logic [W-1:0] exp_d_q[$];
  int           exp_p_q[$];
  string        tag_q[$];

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(int r, int c);
    return W'(r * 4951 + c * 2879) ^ 16'hA5C3;
  endfunction

  task automatic cyc(bit wen, int wr, int wc, logic [W-1:0] wd,
                     bit x, int xr, int xs, int xt, bit sen, string tag);
    wr_en = wen; wr_row = RW'(wr); wr_col = CW'(wc); wr_data = wd;
    xfer_req = x; xfer_row = RW'(xr); xfer_seg = xs[0]; xfer_tap = PW'(xt);
    shift_en = sen;
    if (sen) begin
      if (!x) begin
        out_m = sam_m[ptr_m];
        ptr_m = (ptr_m + 1) % DEPTH;
      end
      exp_d_q.push_back(out_m);
      exp_p_q.push_back(x ? xt : ptr_m);
      tag_q.push_back(tag);
    end
    if (x) begin
      for (int i = 0; i < DEPTH; i++) sam_m[i] = mem_m[xr][xs * DEPTH + i];
      ptr_m = xt;
    end
    if (wen) mem_m[wr][wc] = wd;
    @(negedge clk);
    wr_en = 0; xfer_req = 0; shift_en = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, '0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic shift(int n, string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, '0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (shift_en) begin
        #2;
        if (exp_d_q.size() == 0) check("monitor queue empty", 1, 0);
        else begin
          automatic logic [W-1:0] d = exp_d_q.pop_front();
          automatic int p = exp_p_q.pop_front();
          automatic string t = tag_q.pop_front();
          check({t, " data"}, ser_data, d);
          check({t, " ptr"}, ser_ptr, p);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    check("watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; xfer_req = 0; shift_en = 0;
    wr_row = '0; wr_col = '0; wr_data = '0; xfer_row = '0; xfer_seg = 0; xfer_tap = '0;
    repeat (3) @(negedge clk);
    check("R1 data in reset", ser_data, 0);
    check("R1 ptr in reset", ser_ptr, 0);
    check("R1 valid in reset", ser_valid, 0);
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) cyc(1, r, c, pat(r, c), 0, 0, 0, 0, 0, "");
    check("R9 valid low before transfer", ser_valid, 0);

    cyc(0, 0, 0, '0, 1, 1, 0, 0, 0, "R3");
    check("R9 valid after transfer", ser_valid, 1);
    check("R3 ptr at tap", ser_ptr, 0);
    shift(255, "R4 ascending");
    shift(3, "R5 wrap");

    begin
      automatic int d0 = ser_data;
      automatic int p0 = ser_ptr;
      idle(3);
      check("R6 data held", ser_data, d0);
      check("R6 ptr held", ser_ptr, p0);
    end

    cyc(0, 0, 0, '0, 1, 2, 1, 250, 0, "R3");
    check("R3 ptr at tap 250", ser_ptr, 250);
    shift(10, "R5 wrap from tap");

    cyc(0, 0, 0, '0, 1, 0, 1, 17, 1, "R7 collision");
    shift(4, "R7 after collision");

    cyc(1, 3, 256 + 5, 16'hBEEF, 1, 3, 1, 5, 0, "R8");
    for (int k = 0; k < 4; k++)
      cyc(1, 3, 256 + 6 + k, ~pat(3, 256 + 6 + k), 0, 0, 0, 0, 1, "R8 old data kept");
    shift(2, "R8 old data kept");

    cyc(0, 0, 0, '0, 1, 3, 1, 5, 0, "R2");
    shift(6, "R2 new data visible");
    check("R9 valid sticky", ser_valid, 1);

    idle(3);
    check("scoreboard drained", exp_d_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule